// File: doc/BRIEF.md
# Encoder Link Health Monitor

This block watches the feedback path of a motion axis and raises discrete fault lines for a safety monitor. It takes three kinds of evidence. The first is edge activity on the two incremental quadrature channels. The second is the position values reported by two redundant decode chains. The third is the per-frame result pulses of a serial absolute-encoder receiver: CRC error, framing error, retry and timeout. The quadrature inputs are assumed to be already synchronised to `clk`.

Each category of serial error is counted in its own saturating counter. The counters, together with the sticky fault flags, are exposed as plain output words, so that a safety processor can read them like status registers. The thresholds, tolerances, timeouts and per-flag enables arrive as configuration inputs.

Each fault flag stays set until a single clear strobe resets it. The same strobe resets all counters. A combined fault line is the OR of those flags whose enable bit is set.

Top module: `enc_link_monitor`

## Requirements
- R1: After reset, all three counters are zero, all four flags are zero and `fault` is low.
- R2: The CRC, framing and retry counters each increment by one on every clock in which their own input pulse is high, independently of one another.
- R3: A counter that holds its maximum value (2^CNT_W-1) stays there on further pulses.
- R4: `clr` high for one clock returns all counters and all flags to zero. It takes priority over any event in the same clock.
- R5: While `motion_exp` is high, `link_loss` sets on the `wd_limit`-th consecutive clock without a change on `enc_a` or `enc_b`. Any change restarts the count.
- R6: While `motion_exp` is low, the idle count is held at zero and `link_loss` never newly sets.
- R7: On each clock with `pos_valid` high, the distance between `pos_a` and `pos_b` is compared with `pos_tol`. The distance is the shortest signed distance modulo 2^POS_W. `disagree` sets when the distance exceeds `pos_tol` on `persist_n` consecutive valid samples, with 0 treated as 1. A valid sample inside the tolerance restarts the run, and clocks without `pos_valid` leave the run unchanged.
- R8: `ser_thr` sets one clock after the CRC count or the framing count is at or above `err_thresh`. An `err_thresh` of 0 disables the check.
- R9: A `timeout` pulse sets `tmo_flag` at the next clock edge.
- R10: Every flag stays set until `clr`.
- R11: `flags` carries link loss in bit 0, disagreement in bit 1, serial threshold in bit 2 and timeout in bit 3. `fault` is the OR of `flags & flag_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Clear strobe for counters and flags |
| enc_a | input | 1 | Incremental channel A (synchronised) |
| enc_b | input | 1 | Incremental channel B (synchronised) |
| motion_exp | input | 1 | Axis is expected to be moving |
| wd_limit | input | WD_W | Idle clocks that indicate link loss |
| pos_valid | input | 1 | Position pair is valid this clock |
| pos_a | input | POS_W | Position from decode chain A |
| pos_b | input | POS_W | Position from decode chain B |
| pos_tol | input | POS_W | Allowed absolute difference |
| persist_n | input | PERS_W | Consecutive excess samples needed |
| crc_err | input | 1 | Serial frame CRC error pulse |
| frm_err | input | 1 | Serial framing error pulse |
| retry | input | 1 | Serial retry pulse |
| timeout | input | 1 | Serial timeout pulse |
| err_thresh | input | CNT_W | Serial error count threshold |
| flag_en | input | 4 | Per-flag enable for `fault` |
| crc_cnt | output | CNT_W | CRC error count |
| frm_cnt | output | CNT_W | Framing error count |
| retry_cnt | output | CNT_W | Retry count |
| flags | output | 4 | Sticky flag word |
| link_loss | output | 1 | Link loss flag |
| disagree | output | 1 | Channel disagreement flag |
| ser_thr | output | 1 | Serial threshold flag |
| tmo_flag | output | 1 | Timeout flag |
| fault | output | 1 | Combined enabled fault |

## Verification
The serial counters are driven with random, overlapping pulses on all three error inputs. This separates the counters from one another and confirms that the threshold flag follows the counts with one clock of lag. The comparator is driven with random position pairs that lie just inside or just outside the tolerance. These pairs include differences across the wrap point and gaps in `pos_valid`, so a run that restarts wrongly or a non-wrapping distance shows up as a wrong flag. Directed cases then cover:
- idle counting up to exactly `wd_limit`, with restart by an edge and suppression when no motion is expected;
- counter saturation;
- a clear strobe in the same clock as an event;
- every enable mask on the combined fault.

// File: rtl/enc_mon_pkg.sv
package enc_mon_pkg;
   localparam int NUM_FLAGS = 4;
   localparam int NUM_CNT   = 3;
   typedef enum logic [1:0] {
      FL_LINK = 2'd0,
      FL_DIS  = 2'd1,
      FL_SER  = 2'd2,
      FL_TMO  = 2'd3
   } flag_idx_e;
   typedef enum logic [1:0] {
      CT_CRC   = 2'd0,
      CT_FRM   = 2'd1,
      CT_RETRY = 2'd2
   } cnt_idx_e;
endpackage

// File: rtl/elm_sat_counter.sv
module elm_sat_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] MAX = '1;

   if (W < 2) begin : g_bad_w
      $error("elm_sat_counter: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (clr)               cnt <= '0;
      else if (inc && cnt != MAX) cnt <= cnt + 1'b1;
   end

   AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == MAX && !clr) |=> (cnt == MAX)); // R3
   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0)); // R4
endmodule

// File: rtl/elm_activity_wd.sv
module elm_activity_wd #(
   parameter int WD_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            enc_a,
   input  logic            enc_b,
   input  logic            motion_exp,
   input  logic [WD_W-1:0] wd_limit,
   output logic            link_loss
);
   localparam logic [WD_W:0] ONE = (WD_W+1)'(1);

   if (WD_W < 2) begin : g_bad_w
      $error("elm_activity_wd: WD_W must be at least 2");
   end

   logic [1:0]      prev_ab;
   logic [WD_W-1:0] idle_cnt;
   logic            act;
   logic            reach;

   assign act   = ({enc_a, enc_b} != prev_ab);
   assign reach = (({1'b0, idle_cnt} + ONE) >= {1'b0, wd_limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_ab   <= 2'b00;
         idle_cnt  <= '0;
         link_loss <= 1'b0;
      end else begin
         prev_ab <= {enc_a, enc_b};
         if (clr) begin
            idle_cnt  <= '0;
            link_loss <= 1'b0;
         end else if (!motion_exp || act) begin
            idle_cnt <= '0;
         end else if (reach) begin
            link_loss <= 1'b1;
         end else begin
            idle_cnt <= idle_cnt + 1'b1;
         end
      end
   end

   AST_NO_LOSS_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
      (!motion_exp && !link_loss) |=> !link_loss); // R6
   AST_LOSS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (link_loss && !clr) |=> link_loss); // R10
endmodule

// File: rtl/elm_pos_compare.sv
module elm_pos_compare #(
   parameter int POS_W    = 16,
   parameter int PERS_W   = 4,
   parameter bit POS_WRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              pos_valid,
   input  logic [POS_W-1:0]  pos_a,
   input  logic [POS_W-1:0]  pos_b,
   input  logic [POS_W-1:0]  pos_tol,
   input  logic [PERS_W-1:0] persist_n,
   output logic              disagree
);
   localparam logic [PERS_W-1:0] RUN_MAX = '1;

   if (POS_W < 2 || PERS_W < 1) begin : g_bad_w
      $error("elm_pos_compare: POS_W >= 2 and PERS_W >= 1 required");
   end

   logic [POS_W-1:0]  absd;
   logic [PERS_W-1:0] run;
   logic [PERS_W-1:0] need;
   logic [PERS_W:0]   run_nx;
   logic              excess;

   if (POS_WRAP) begin : g_wrap
      logic [POS_W-1:0] d;
      assign d    = pos_a - pos_b;
      assign absd = d[POS_W-1] ? (~d + 1'b1) : d;
   end else begin : g_lin
      assign absd = (pos_a >= pos_b) ? (pos_a - pos_b) : (pos_b - pos_a);
   end

   assign excess = (absd > pos_tol);
   assign need   = (persist_n == '0) ? PERS_W'(1) : persist_n;
   assign run_nx = {1'b0, run} + (PERS_W+1)'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= '0;
         disagree <= 1'b0;
      end else if (clr) begin
         run      <= '0;
         disagree <= 1'b0;
      end else if (pos_valid) begin
         if (excess) begin
            if (run != RUN_MAX) run <= run + 1'b1;
            if (run_nx >= {1'b0, need}) disagree <= 1'b1;
         end else begin
            run <= '0;
         end
      end
   end

   AST_IN_TOL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_valid && !excess && !disagree) |=> !disagree); // R7
   AST_DIS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (disagree && !clr) |=> disagree); // R10
endmodule

// File: rtl/enc_link_monitor.sv
module enc_link_monitor
   import enc_mon_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int WD_W     = 16,
   parameter int POS_W    = 16,
   parameter int PERS_W   = 4,
   parameter bit POS_WRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              enc_a,
   input  logic              enc_b,
   input  logic              motion_exp,
   input  logic [WD_W-1:0]   wd_limit,
   input  logic              pos_valid,
   input  logic [POS_W-1:0]  pos_a,
   input  logic [POS_W-1:0]  pos_b,
   input  logic [POS_W-1:0]  pos_tol,
   input  logic [PERS_W-1:0] persist_n,
   input  logic              crc_err,
   input  logic              frm_err,
   input  logic              retry,
   input  logic              timeout,
   input  logic [CNT_W-1:0]  err_thresh,
   input  logic [3:0]        flag_en,
   output logic [CNT_W-1:0]  crc_cnt,
   output logic [CNT_W-1:0]  frm_cnt,
   output logic [CNT_W-1:0]  retry_cnt,
   output logic [3:0]        flags,
   output logic              link_loss,
   output logic              disagree,
   output logic              ser_thr,
   output logic              tmo_flag,
   output logic              fault
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("enc_link_monitor: CNT_W must be at least 2");
   end

   logic [NUM_CNT-1:0] ev;
   logic [CNT_W-1:0]   cnts [NUM_CNT];
   logic               ser_hit;

   assign ev[CT_CRC]   = crc_err;
   assign ev[CT_FRM]   = frm_err;
   assign ev[CT_RETRY] = retry;

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      elm_sat_counter #(.W(CNT_W)) i_cnt (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clr),
         .inc   (ev[i]),
         .cnt   (cnts[i])
      );
   end

   assign crc_cnt   = cnts[CT_CRC];
   assign frm_cnt   = cnts[CT_FRM];
   assign retry_cnt = cnts[CT_RETRY];

   elm_activity_wd #(.WD_W(WD_W)) i_wd (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .enc_a      (enc_a),
      .enc_b      (enc_b),
      .motion_exp (motion_exp),
      .wd_limit   (wd_limit),
      .link_loss  (link_loss)
   );

   elm_pos_compare #(.POS_W(POS_W), .PERS_W(PERS_W), .POS_WRAP(POS_WRAP)) i_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .pos_valid (pos_valid),
      .pos_a     (pos_a),
      .pos_b     (pos_b),
      .pos_tol   (pos_tol),
      .persist_n (persist_n),
      .disagree  (disagree)
   );

   assign ser_hit = (err_thresh != '0) &&
                    ((crc_cnt >= err_thresh) || (frm_cnt >= err_thresh));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ser_thr  <= 1'b0;
         tmo_flag <= 1'b0;
      end else if (clr) begin
         ser_thr  <= 1'b0;
         tmo_flag <= 1'b0;
      end else begin
         if (ser_hit) ser_thr  <= 1'b1;
         if (timeout) tmo_flag <= 1'b1;
      end
   end

   always_comb begin
      flags          = '0;
      flags[FL_LINK] = link_loss;
      flags[FL_DIS]  = disagree;
      flags[FL_SER]  = ser_thr;
      flags[FL_TMO]  = tmo_flag;
   end

   assign fault = |(flags & flag_en);

   AST_TMO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout && !clr) |=> tmo_flag); // R9
   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((flags & $past(flags)) == $past(flags))); // R10
   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (flags == 4'b0000)); // R4
   AST_SER_THR_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (err_thresh == '0 && !ser_thr) |=> !ser_thr); // R8
endmodule

// File: tb/test_enc_link_monitor.sv
module test_enc_link_monitor;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W  = 8;
   localparam int WD_W   = 16;
   localparam int POS_W  = 16;
   localparam int PERS_W = 4;
   localparam int CMAX   = (1 << CNT_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              clr = 1'b0;
   logic              enc_a = 1'b0, enc_b = 1'b0, motion_exp = 1'b0;
   logic [WD_W-1:0]   wd_limit = 16'd10;
   logic              pos_valid = 1'b0;
   logic [POS_W-1:0]  pos_a = '0, pos_b = '0, pos_tol = 16'd4;
   logic [PERS_W-1:0] persist_n = 4'd3;
   logic              crc_err = 1'b0, frm_err = 1'b0, retry = 1'b0, timeout = 1'b0;
   logic [CNT_W-1:0]  err_thresh = '0;
   logic [3:0]        flag_en = 4'hF;
   logic [CNT_W-1:0]  crc_cnt, frm_cnt, retry_cnt;
   logic [3:0]        flags;
   logic              link_loss, disagree, ser_thr, tmo_flag, fault;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   enc_link_monitor #(.CNT_W(CNT_W), .WD_W(WD_W), .POS_W(POS_W), .PERS_W(PERS_W))
   i_enc_link_monitor (
      .clk(clk), .rst_n(rst_n), .clr(clr), .enc_a(enc_a), .enc_b(enc_b),
      .motion_exp(motion_exp), .wd_limit(wd_limit), .pos_valid(pos_valid),
      .pos_a(pos_a), .pos_b(pos_b), .pos_tol(pos_tol), .persist_n(persist_n),
      .crc_err(crc_err), .frm_err(frm_err), .retry(retry), .timeout(timeout),
      .err_thresh(err_thresh), .flag_en(flag_en), .crc_cnt(crc_cnt),
      .frm_cnt(frm_cnt), .retry_cnt(retry_cnt), .flags(flags),
      .link_loss(link_loss), .disagree(disagree), .ser_thr(ser_thr),
      .tmo_flag(tmo_flag), .fault(fault)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int sat_inc(input int v, input bit p);
      return (p && v < CMAX) ? v + 1 : v;
   endfunction

   function automatic int wrap_dist(input int a, input int b);
      int d;
      d = (a - b) & 16'hFFFF;
      if (d >= 32768) d = 65536 - d;
      return d;
   endfunction

   task automatic do_clear();
      clr = 1'b1;
      step();
      clr = 1'b0;
   endtask

   initial begin
      int mc, mf, mr, run, need;
      bit ms, md, mt;
      int ser_thr_v;
      void'($urandom(32'h5EED_0451));

      step();
      step();
      // R1: reset state
      check("R1 crc_cnt", int'(crc_cnt), 0);
      check("R1 flags", int'(flags), 0);
      check("R1 fault", int'(fault), 0);
      rst_n = 1'b1;
      step();

      // R2 R8 R4: random serial pulses against model counters
      mc = 0; mf = 0; mr = 0; ms = 0;
      ser_thr_v = 40;
      err_thresh = CNT_W'(ser_thr_v);
      for (int i = 0; i < 300; i++) begin
         crc_err = ($urandom % 4) == 0;
         frm_err = ($urandom % 5) == 0;
         retry   = ($urandom % 3) == 0;
         clr     = (i == 150);
         step();
         if (clr) begin
            mc = 0; mf = 0; mr = 0; ms = 0;
         end else begin
            if (mc >= ser_thr_v || mf >= ser_thr_v) ms = 1;
            mc = sat_inc(mc, crc_err);
            mf = sat_inc(mf, frm_err);
            mr = sat_inc(mr, retry);
         end
         check("R2 crc_cnt", int'(crc_cnt), mc);
         check("R2 frm_cnt", int'(frm_cnt), mf);
         check("R2 retry_cnt", int'(retry_cnt), mr);
         check("R8 ser_thr", int'(ser_thr), int'(ms));
      end
      crc_err = 0; frm_err = 0; retry = 0; clr = 0;
      do_clear();

      // R8: threshold zero disables, exact crossing timing
      err_thresh = '0;
      frm_err = 1;
      for (int i = 0; i < 5; i++) step();
      frm_err = 0;
      step();
      check("R8 threshold zero off", int'(ser_thr), 0);
      do_clear();
      err_thresh = 8'd3;
      crc_err = 1;
      step(); step(); step();
      crc_err = 0;
      check("R8 count reached, flag lags", int'(ser_thr), 0);
      step();
      check("R8 flag one clock later", int'(ser_thr), 1);

      // R3: saturation
      do_clear();
      err_thresh = '0;
      retry = 1;
      for (int i = 0; i < CMAX + 10; i++) step();
      retry = 0;
      check("R3 saturated retry", int'(retry_cnt), CMAX);

      // R4: clear wins over same-cycle event
      retry = 1; timeout = 1; clr = 1;
      step();
      retry = 0; timeout = 0; clr = 0;
      check("R4 clear priority count", int'(retry_cnt), 0);
      check("R4 clear priority flag", int'(tmo_flag), 0);

      // R9 R10: timeout flag, sticky
      timeout = 1;
      step();
      timeout = 0;
      check("R9 tmo_flag", int'(tmo_flag), 1);
      for (int i = 0; i < 20; i++) step();
      check("R10 tmo sticky", int'(tmo_flag), 1);
      do_clear();

      // R5: idle timeout exactly at wd_limit
      wd_limit = 16'd10;
      motion_exp = 1;
      for (int i = 0; i < 9; i++) step();
      check("R5 before limit", int'(link_loss), 0);
      step();
      check("R5 at limit", int'(link_loss), 1);
      do_clear();
      // R5: edge restarts count
      for (int i = 0; i < 8; i++) step();
      enc_a = ~enc_a;
      step();
      for (int i = 0; i < 8; i++) step();
      check("R5 edge restarts", int'(link_loss), 0);
      for (int i = 0; i < 3; i++) step();
      check("R5 after restart limit", int'(link_loss), 1);
      do_clear();
      // R6: stationary axis
      motion_exp = 0;
      for (int i = 0; i < 50; i++) step();
      check("R6 no loss at rest", int'(link_loss), 0);

      // R7: random positions near tolerance, incl. wrap
      do_clear();
      pos_tol = 16'd4; persist_n = 4'd3;
      run = 0; md = 0;
      for (int i = 0; i < 600; i++) begin
         int a, dl;
         a  = ($urandom % 3 == 0) ? (65535 - int'($urandom % 4)) : int'($urandom % 65536);
         dl = int'($urandom % 13) - 6;
         pos_a = POS_W'(a);
         pos_b = POS_W'(a + dl);
         pos_valid = ($urandom % 4) != 0;
         clr = ($urandom % 40) == 0;
         persist_n = (i >= 300) ? 4'd0 : 4'd3;
         step();
         need = (persist_n == 0) ? 1 : int'(persist_n);
         if (clr) begin
            run = 0; md = 0;
         end else if (pos_valid) begin
            if (wrap_dist(a, (a + dl) & 16'hFFFF) > 4) begin
               if (run + 1 >= need) md = 1;
               if (run < 15) run++;
            end else run = 0;
         end
         check("R7 disagree", int'(disagree), int'(md));
      end
      clr = 0; pos_valid = 0;

      // R11: flag order and enable mask
      do_clear();
      timeout = 1;
      step();
      timeout = 0;
      check("R11 flags bit3 timeout", int'(flags), 8);
      flag_en = 4'b0111;
      #1;
      check("R11 masked off", int'(fault), 0);
      flag_en = 4'b1000;
      #1;
      check("R11 enabled", int'(fault), 1);
      mt = 1;
      motion_exp = 1; wd_limit = 16'd2;
      step(); step();
      motion_exp = 0;
      check("R11 flags bit0 link", int'(flags), 9);
      flag_en = 4'b0001;
      #1;
      check("R11 link enabled", int'(fault), int'(mt));

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule